// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block keeps the unretired loads of an out-of-order core in a small circular queue. Loads are entered in program order, and each one is marked once its value has been obtained. Every invalidation caused by a remote write is compared against the cache-line address of every queued load. A completed load on the same line is tagged as a possible ordering violation. Barrier retirements are also observed. When the oldest load retires, the block decides whether that load and everything younger must be fetched again.

Two ordering disciplines are selectable at run time. In strict (sequentially consistent) mode, one invalidation tag is enough to demand a refetch. In relaxed mode, a second tag is also needed: it is set when a barrier retires while the invalidation tag is already present. A refetch, or an external flush, empties the whole queue and drops every tag. The re-execution itself, the store queue and the cache sit outside this block.

Top module: `lqv_detector`

## Requirements
- R1: After reset the queue is empty (`lq_empty`=1, `lq_full`=0), `alloc_idx` is 0 and `refetch` is 0.
- R2: An accepted allocation fills slot `alloc_idx`, which then advances by one, modulo DEPTH. With DEPTH loads held, `lq_full` is 1, and any further allocation is ignored: `alloc_idx` and the occupancy stay unchanged.
- R3: `retire_valid` removes the oldest load. A retire request on an empty queue is ignored.
- R4: An invalidation compares `inv_addr[ADDR_W-1:OFF_W]` with the same bits of each load's address, so the low OFF_W offset bits play no part. Every completed load on a matching line receives the invalidation tag.
- R5: A load that has not completed is never tagged. This includes a load whose completion arrives in the same cycle as the invalidation.
- R6: In strict mode (`relaxed_mode`=0), retiring an oldest load that carries the invalidation tag raises `refetch` in that same cycle. Retiring a load without the tag does not, and barriers have no effect.
- R7: An invalidation that matches the oldest completed load in the cycle that load retires counts toward that cycle's refetch decision.
- R8: In relaxed mode (`relaxed_mode`=1), a barrier retirement gives the barrier tag to every load that already holds the invalidation tag. An invalidation that arrives after the barrier does not earn the barrier tag.
- R9: In relaxed mode, retirement raises `refetch` only when both tags are present. A load that holds only the invalidation tag retires silently.
- R10: A refetch, or `flush`=1, empties the queue at the next edge and returns `alloc_idx` to 0. An allocation requested in that same cycle is dropped.
- R11: In relaxed mode, a barrier retirement in the same cycle as the retirement of an invalidation-tagged oldest load counts toward that cycle's refetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| relaxed_mode | input | 1 | 0 strict ordering, 1 relaxed ordering with barriers |
| alloc_valid | input | 1 | Enter a new load at the tail |
| alloc_addr | input | ADDR_W | Byte address of the new load |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation fills |
| cmp_valid | input | 1 | A load's value has been obtained |
| cmp_idx | input | log2(DEPTH) | Slot of the completing load |
| inv_valid | input | 1 | Invalidation from a remote write |
| inv_addr | input | ADDR_W | Byte address of the invalidation |
| barrier_retire | input | 1 | A memory barrier retires |
| retire_valid | input | 1 | Retire the oldest load |
| flush | input | 1 | Empty the queue |
| refetch | output | 1 | Refetch the retiring load and all younger work |
| lq_full | output | 1 | Queue holds DEPTH loads |
| lq_empty | output | 1 | Queue holds no loads |

## Verification
`refetch` is a combinational function of the queue state and the inputs of the current cycle. The bench therefore drives inputs just after the falling edge and samples one time unit later, before the rising edge that consumes them. `alloc_idx`, `lq_full` and `lq_empty` change only on the edge after a stimulus, so the result of an allocation, retire, flush or refetch is checked in the next cycle's sample. A behavioural queue model advances on each rising edge and predicts every output for every cycle. Hand-computed refetch values are also checked at each retirement that matters.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
   // Per-slot status bits of a queued load
   typedef struct packed {
      logic vld;     // slot holds an unretired load
      logic done;    // value already obtained
      logic mk_inv;  // remote write hit this line after completion
      logic mk_bar;  // barrier retired while mk_inv was set
   } lqv_flags_t;
endpackage

// File: rtl/lqv_entry.sv
module lqv_entry
   import lqv_pkg::*;
#(
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              alloc_we,
   input  logic [LINE_W-1:0] alloc_line,
   input  logic              cmp_we,
   input  logic              retire_we,
   input  logic              inv_valid,
   input  logic [LINE_W-1:0] inv_line,
   input  logic              bar_retire,
   output lqv_flags_t        flags,
   output logic              inv_hit
);
   logic [LINE_W-1:0] line_q;
   lqv_flags_t        flags_q;

   assign inv_hit = flags_q.vld & flags_q.done & inv_valid & (line_q == inv_line);
   assign flags   = flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         line_q  <= '0;
      end else if (clr) begin
         flags_q <= '0;
      end else if (alloc_we) begin
         flags_q <= '{vld: 1'b1, done: 1'b0, mk_inv: 1'b0, mk_bar: 1'b0};
         line_q  <= alloc_line;
      end else begin
         if (retire_we)                    flags_q.vld    <= 1'b0;
         if (cmp_we && flags_q.vld)        flags_q.done   <= 1'b1;
         if (inv_hit)                      flags_q.mk_inv <= 1'b1;
         if (bar_retire && flags_q.mk_inv) flags_q.mk_bar <= 1'b1;
      end
   end

   // R5: a fresh invalidation tag needs a load that was already complete
   assert_tag_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q.mk_inv) |-> $past(flags_q.done));
   // R8: the barrier tag only lands on a load already tagged by an invalidation
   assert_bar_after_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q.mk_bar) |-> $past(flags_q.mk_inv));
   // R10: clearing empties the slot
   assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flags_q.vld);
endmodule

// File: rtl/lqv_ptrs.sv
module lqv_ptrs #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   output logic [IW-1:0] head_idx,
   output logic [IW-1:0] tail_idx,
   output logic          full,
   output logic          empty
);
   logic [IW:0] head_q, tail_q, used;

   assign used     = tail_q - head_q;
   assign full     = (used == (IW+1)'(DEPTH));
   assign empty    = (used == '0);
   assign head_idx = head_q[IW-1:0];
   assign tail_idx = tail_q[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (pop)  head_q <= head_q + 1'b1;
         if (push) tail_q <= tail_q + 1'b1;
      end
   end

   // R2: occupancy never exceeds the queue size
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      used <= (IW+1)'(DEPTH));
endmodule

// File: rtl/lqv_detector.sv
module lqv_detector
   import lqv_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   localparam int IW     = $clog2(DEPTH),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              relaxed_mode,
   input  logic              alloc_valid,
   input  logic [ADDR_W-1:0] alloc_addr,
   output logic [IW-1:0]     alloc_idx,
   input  logic              cmp_valid,
   input  logic [IW-1:0]     cmp_idx,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic              barrier_retire,
   input  logic              retire_valid,
   input  logic              flush,
   output logic              refetch,
   output logic              lq_full,
   output logic              lq_empty
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("lqv_detector: DEPTH must be a power of two of at least 2");
   end
   if (OFF_W < 0 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("lqv_detector: OFF_W must lie below ADDR_W");
   end

   logic [IW-1:0] head_idx, tail_idx;
   logic          ret_fire, alloc_fire, clr_all;
   lqv_flags_t    ent_flags [DEPTH];
   logic          ent_hit   [DEPTH];
   lqv_flags_t    head_f;
   logic          eff_inv, eff_bar, violation;

   assign ret_fire   = retire_valid & ~lq_empty;
   assign clr_all    = flush | refetch;
   assign alloc_fire = alloc_valid & ~lq_full & ~clr_all;
   assign alloc_idx  = tail_idx;

   lqv_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_all),
      .push     (alloc_fire),
      .pop      (ret_fire),
      .head_idx (head_idx),
      .tail_idx (tail_idx),
      .full     (lq_full),
      .empty    (lq_empty)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      lqv_entry #(.LINE_W(LINE_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (clr_all),
         .alloc_we   (alloc_fire && (tail_idx == IW'(i))),
         .alloc_line (alloc_addr[ADDR_W-1:OFF_W]),
         .cmp_we     (cmp_valid && (cmp_idx == IW'(i))),
         .retire_we  (ret_fire && (head_idx == IW'(i))),
         .inv_valid  (inv_valid),
         .inv_line   (inv_addr[ADDR_W-1:OFF_W]),
         .bar_retire (barrier_retire),
         .flags      (ent_flags[i]),
         .inv_hit    (ent_hit[i])
      );
   end

   // Decision for the oldest load, folding in same-cycle events
   assign head_f    = ent_flags[head_idx];
   assign eff_inv   = head_f.mk_inv | ent_hit[head_idx];
   assign eff_bar   = head_f.mk_bar | (barrier_retire & head_f.mk_inv);
   assign violation = relaxed_mode ? (eff_inv & eff_bar) : eff_inv;
   assign refetch   = ret_fire & violation;

   // R6: a refetch only comes with a real retirement
   assert_refetch_on_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      refetch |-> (retire_valid && !lq_empty));
   // R10: a refetch leaves the queue empty
   assert_refetch_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      refetch |=> lq_empty);
   // R2: a full queue with no retire or flush keeps its tail
   assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lq_full && !retire_valid && !flush) |=> (lq_full && $stable(alloc_idx)));
   // R9: in relaxed mode a refetch needs a barrier tag on the oldest load
   assert_relaxed_needs_bar_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (relaxed_mode && refetch) |-> (head_f.mk_bar || (barrier_retire && head_f.mk_inv)));
endmodule

// File: tb/tb_lqv_detector.sv
module tb_lqv_detector;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 8;
   localparam int ADDR_W = 32;
   localparam int OFF_W  = 6;
   localparam int IW     = $clog2(DEPTH);
   localparam int LINE_W = ADDR_W - OFF_W;

   logic clk = 0, rst_n = 0;
   logic relaxed_mode = 0, alloc_valid = 0, cmp_valid = 0, inv_valid = 0;
   logic barrier_retire = 0, retire_valid = 0, flush = 0;
   logic [ADDR_W-1:0] alloc_addr = '0, inv_addr = '0;
   logic [IW-1:0] cmp_idx = '0, alloc_idx;
   logic refetch, lq_full, lq_empty;

   int checks = 0, failures = 0;
   int hand_rf = -1;
   bit finished = 0;

   // behavioural model state
   bit          m_vld [DEPTH], m_done [DEPTH], m_inv [DEPTH], m_bar [DEPTH];
   int          m_line [DEPTH];
   int          m_head = 0, m_tail = 0, m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lqv_detector #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) dut (
      .clk(clk), .rst_n(rst_n), .relaxed_mode(relaxed_mode),
      .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_idx(alloc_idx),
      .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .inv_valid(inv_valid),
      .inv_addr(inv_addr), .barrier_retire(barrier_retire),
      .retire_valid(retire_valid), .flush(flush), .refetch(refetch),
      .lq_full(lq_full), .lq_empty(lq_empty));

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int lineof(logic [ADDR_W-1:0] a);
      return int'(a >> OFF_W);
   endfunction

   function automatic bit model_rf();
      bit ei, eb;
      if (!(retire_valid && m_cnt > 0)) return 0;
      ei = m_inv[m_head] || (inv_valid && m_done[m_head] && m_vld[m_head]
                             && m_line[m_head] == lineof(inv_addr));
      eb = m_bar[m_head] || (barrier_retire && m_inv[m_head]);
      return relaxed_mode ? (ei && eb) : ei;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < DEPTH; i++) begin
         m_vld[i] = 0; m_done[i] = 0; m_inv[i] = 0; m_bar[i] = 0;
      end
      m_head = 0; m_tail = 0; m_cnt = 0;
   endtask

   task automatic model_step(bit rf);
      bit hit [DEPTH];
      if (flush || rf) begin
         model_clear();
         return;
      end
      for (int i = 0; i < DEPTH; i++)
         hit[i] = inv_valid && m_vld[i] && m_done[i] && m_line[i] == lineof(inv_addr);
      for (int i = 0; i < DEPTH; i++) begin
         if (barrier_retire && m_inv[i]) m_bar[i] = 1;
         if (hit[i]) m_inv[i] = 1;
      end
      if (cmp_valid && m_vld[cmp_idx]) m_done[cmp_idx] = 1;
      if (alloc_valid && m_cnt < DEPTH) begin
         if (retire_valid && m_cnt > 0) begin
            m_vld[m_head] = 0; m_head = (m_head + 1) % DEPTH; m_cnt--;
         end
         m_vld[m_tail] = 1; m_done[m_tail] = 0; m_inv[m_tail] = 0; m_bar[m_tail] = 0;
         m_line[m_tail] = lineof(alloc_addr);
         m_tail = (m_tail + 1) % DEPTH; m_cnt++;
      end else if (retire_valid && m_cnt > 0) begin
         m_vld[m_head] = 0; m_head = (m_head + 1) % DEPTH; m_cnt--;
      end
   endtask

   // one cycle: inputs already driven after a falling edge
   task automatic cyc(string tag);
      bit rf;
      #1;
      rf = model_rf();
      chk(tag, "refetch", refetch, rf);
      chk(tag, "lq_full", lq_full, m_cnt == DEPTH);
      chk(tag, "lq_empty", lq_empty, m_cnt == 0);
      chk(tag, "alloc_idx", alloc_idx, m_tail);
      if (hand_rf >= 0) chk(tag, "refetch(hand)", refetch, hand_rf);
      hand_rf = -1;
      @(posedge clk);
      model_step(rf);
      @(negedge clk);
      alloc_valid = 0; cmp_valid = 0; inv_valid = 0;
      barrier_retire = 0; retire_valid = 0; flush = 0;
   endtask

   task automatic do_alloc(string tag, logic [ADDR_W-1:0] a);
      alloc_valid = 1; alloc_addr = a; cyc(tag);
   endtask
   task automatic do_cmp(string tag, int idx);
      cmp_valid = 1; cmp_idx = IW'(idx); cyc(tag);
   endtask
   task automatic do_inv(string tag, logic [ADDR_W-1:0] a);
      inv_valid = 1; inv_addr = a; cyc(tag);
   endtask
   task automatic do_bar(string tag);
      barrier_retire = 1; cyc(tag);
   endtask
   task automatic do_ret(string tag, int exp_rf);
      retire_valid = 1; hand_rf = exp_rf; cyc(tag);
   endtask
   task automatic one_load(string tag, logic [ADDR_W-1:0] a);
      int s;
      s = m_tail;
      do_alloc(tag, a);
      do_cmp(tag, s);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      #1;
      chk("R1", "lq_empty", lq_empty, 1);
      chk("R1", "lq_full", lq_full, 0);
      chk("R1", "alloc_idx", alloc_idx, 0);
      chk("R1", "refetch", refetch, 0);
      cyc("R1");

      // R2: fill in order, then an ignored allocation
      for (int i = 0; i < DEPTH; i++) do_alloc("R2", ADDR_W'(i << OFF_W));
      #1; chk("R2", "full after fill", lq_full, 1); chk("R2", "idx wrap", alloc_idx, 0);
      do_alloc("R2", 32'h0000_9000);
      #1; chk("R2", "idx after ignored alloc", alloc_idx, 0);
      // R3: retire all, then one extra on empty
      for (int i = 0; i < DEPTH; i++) do_ret("R3", 0);
      do_ret("R3", 0);
      #1; chk("R3", "empty after drain", lq_empty, 1);

      // strict mode
      relaxed_mode = 0;
      one_load("R4", 32'h0000_1000);
      one_load("R4", 32'h0000_2000);
      do_inv("R4", 32'h0000_1034);        // same line, other offset
      do_ret("R6", 1);
      #1; chk("R10", "empty after refetch", lq_empty, 1); chk("R10", "idx reset", alloc_idx, 0);

      one_load("R4", 32'h0000_1000);
      do_inv("R4", 32'h0000_1040);        // neighbouring line
      do_ret("R4", 0);

      do_alloc("R5", 32'h0000_3000);
      do_inv("R5", 32'h0000_3000);        // not yet complete
      do_cmp("R5", 0);
      do_ret("R5", 0);
      do_alloc("R5", 32'h0000_3000);
      cmp_valid = 1; cmp_idx = IW'(m_head); inv_valid = 1; inv_addr = 32'h0000_3000;
      cyc("R5");
      do_ret("R5", 0);

      one_load("R7", 32'h0000_5000);
      retire_valid = 1; inv_valid = 1; inv_addr = 32'h0000_5008; hand_rf = 1;
      cyc("R7");

      one_load("R6", 32'h0000_6000);
      do_bar("R6");
      do_ret("R6", 0);

      // relaxed mode
      relaxed_mode = 1;
      one_load("R9", 32'h0000_7000);
      do_inv("R9", 32'h0000_7000);
      do_ret("R9", 0);

      one_load("R8", 32'h0000_7000);
      one_load("R8", 32'h0000_8000);
      do_inv("R8", 32'h0000_7010);
      do_bar("R8");
      do_ret("R8", 1);

      one_load("R8", 32'h0000_7000);
      do_bar("R8");
      do_inv("R8", 32'h0000_7000);
      do_ret("R8", 0);

      one_load("R11", 32'h0000_a000);
      do_inv("R11", 32'h0000_a000);
      retire_valid = 1; barrier_retire = 1; hand_rf = 1;
      cyc("R11");

      // R10: flush with a same-cycle allocation
      one_load("R10", 32'h0000_b000);
      do_alloc("R10", 32'h0000_c000);
      flush = 1; alloc_valid = 1; alloc_addr = 32'h0000_d000;
      cyc("R10");
      #1; chk("R10", "empty after flush", lq_empty, 1); chk("R10", "idx after flush", alloc_idx, 0);
      cyc("R10");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule